// File: doc/BRIEF.md
# Power-Up Configuration Loader

This block fetches a configuration word exactly once after reset and then holds it until the next reset. The source is picked by one three-level strap, seen here as a 2-bit code. There are three possible sources:

- **Wired:** the word is all zeros.
- **Serial memory:** the block acts as master of a 3-wire serial memory. It generates the memory clock itself, drives a read command back out on the strap pin, and shifts in the returned bits.
- **Host-clocked:** an external controller supplies a clock, and the block captures one data bit on each rising edge of that clock.

Data bits are assigned least significant bit first. The word carries the following fields:

- Bits 15..11: the station address.
- Bit 7: a flag that disables the isolate control.
- Bit 6: a flag that selects repeater behaviour.
- All other bits are unused.

Top module: `cfg_loader`

## Requirements
- R1: While rst_n is low, cfg_done, cfg_word, rom_sck and strap_oe are all 0.
- R2: strap_mode is sampled only on the first clock edge after reset. Later changes to it do not alter the source or the result.
- R3: strap_mode 2'b00 (wired) sets cfg_done on the first clock edge after reset, with cfg_word all zeros. ser_din and host_sck have no effect in this mode.
- R4: In serial memory mode, rom_sck stays high for HALF_DIV clock cycles and low for HALF_DIV clock cycles. In every other state it stays low.
- R5: In serial memory mode (strap_mode 2'b10 or 2'b11), strap_oe is high. strap_dout presents nine command bits in the order 1, 1, 0, 0, 0, 0, 0, 0, 0, one per rom_sck period. It changes only while rom_sck is low.
- R6: In serial memory mode, ser_din is sampled in the last clock cycle before the falling edge of rom_sck periods 10 through 25. The first sample goes to cfg_word bit 0 and the last to bit 15.
- R7: After the 25th rom_sck period, cfg_done rises, rom_sck stays low and strap_oe drops. Exactly 25 rising edges are produced in total.
- R8: In host-clocked mode (strap_mode 2'b01), host_sck and ser_din pass through a two-stage synchronizer. ser_din is captured on each of the first 16 rising edges of host_sck, first bit to bit 0. cfg_done stays low until the 16th edge.
- R9: Once cfg_done is high, it stays high and cfg_word no longer changes. Further host_sck edges and ser_din values have no effect.
- R10: cfg_word reads zero until cfg_done rises. The loaded value appears together with cfg_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_mode | input | 2 | Strap level: 00 low, 01 high, 1x floating |
| rom_sck | output | 1 | Serial clock to the memory |
| strap_dout | output | 1 | Command bit driven back on the strap pin |
| strap_oe | output | 1 | Drive enable for strap_dout |
| ser_din | input | 1 | Serial data from the memory or the host |
| host_sck | input | 1 | Clock supplied by the host |
| cfg_word | output | CFG_W | Loaded configuration word |
| cfg_done | output | 1 | Load complete |

## Verification
In serial memory mode, the capture of the last data bit falls in the same cycle as the falling edge of rom_sck, and that edge also ends the clock generation. The bench sweeps a walking one and several dense patterns through both floating codes. For each run it checks three things: the word, that exactly 25 clock pulses were produced, and that the clock is low once done is seen. In host mode, extra host clock edges arrive right after the 16th, together with done. Those runs check that the held word is unaffected.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   typedef enum logic [1:0] {
      ST_INIT = 2'd0,
      ST_ROM  = 2'd1,
      ST_HOST = 2'd2,
      ST_DONE = 2'd3
   } ld_state_t;

   localparam logic [1:0] STRAP_LOW  = 2'b00;
   localparam logic [1:0] STRAP_HIGH = 2'b01;
endpackage

// File: rtl/cfgl_clkdiv.sv
module cfgl_clkdiv #(
   parameter int HALF_DIV = 225
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic fall_p
);
   localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   generate
      if (HALF_DIV < 2) begin : g_bad_div
         $error("cfgl_clkdiv: HALF_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (cnt == LAST) begin
         cnt <= '0;
         sck <= ~sck;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign fall_p = run && sck && (cnt == LAST);

   p_half_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt != LAST) |=> (!run || $stable(sck)));
endmodule

// File: rtl/cfgl_sync_edge.sv
module cfgl_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a_clk,
   input  logic a_dat,
   output logic rise_p,
   output logic dat_s
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgl_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] ck_q;
   logic [STAGES-1:0] d_q;
   logic              ck_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_q    <= '0;
         d_q     <= '0;
         ck_prev <= 1'b0;
      end else begin
         ck_q    <= {ck_q[STAGES-2:0], a_clk};
         d_q     <= {d_q[STAGES-2:0], a_dat};
         ck_prev <= ck_q[STAGES-1];
      end
   end

   assign rise_p = ck_q[STAGES-1] & ~ck_prev;
   assign dat_s  = d_q[STAGES-1];

   p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_p |=> !rise_p);
endmodule

// File: rtl/cfgl_lsb_shift.sv
module cfgl_lsb_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] word,
   output logic         full
);
   localparam int NW = $clog2(W + 1);
   localparam logic [NW-1:0] FULL_CNT = NW'(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("cfgl_lsb_shift: W must be at least 2");
      end
   endgenerate

   logic [NW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
         cnt  <= '0;
      end else if (shift_en && !full) begin
         word <= {bit_in, word[W-1:1]};
         cnt  <= cnt + 1'b1;
      end
   end

   assign full = (cnt == FULL_CNT);

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL_CNT);
   p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> (full && $stable(word)));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfgl_pkg::*;
#(
   parameter int CFG_W       = 16,
   parameter int ADDR_W      = 6,
   parameter int HALF_DIV    = 225,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       strap_mode,
   output logic             rom_sck,
   output logic             strap_dout,
   output logic             strap_oe,
   input  logic             ser_din,
   input  logic             host_sck,
   output logic [CFG_W-1:0] cfg_word,
   output logic             cfg_done
);
   localparam int CMD_W = 3 + ADDR_W;
   localparam int TOTAL = CMD_W + CFG_W;
   localparam int BW    = $clog2(TOTAL + 1);
   localparam logic [CMD_W-1:0] CMD_BITS = {3'b110, {ADDR_W{1'b0}}};
   localparam logic [BW-1:0]    CMD_END  = BW'(CMD_W);

   ld_state_t        st;
   logic             run, sck_fall;
   logic             host_rise, host_dat;
   logic             shift_en, bit_in, sh_full;
   logic [CFG_W-1:0] sh_word;
   logic [BW-1:0]    bit_idx;
   logic [CMD_W-1:0] cmd_sh;

   assign run = (st == ST_ROM);

   cfgl_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .sck(rom_sck), .fall_p(sck_fall)
   );

   cfgl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .a_clk(host_sck), .a_dat(ser_din),
      .rise_p(host_rise), .dat_s(host_dat)
   );

   assign shift_en = (st == ST_ROM && sck_fall && bit_idx >= CMD_END) ||
                     (st == ST_HOST && host_rise);
   assign bit_in   = (st == ST_ROM) ? ser_din : host_dat;

   cfgl_lsb_shift #(.W(CFG_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(bit_in),
      .word(sh_word), .full(sh_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_INIT;
         bit_idx  <= '0;
         cfg_word <= '0;
         cfg_done <= 1'b0;
      end else begin
         unique case (st)
            ST_INIT: begin
               if (strap_mode == STRAP_LOW) begin
                  st       <= ST_DONE;
                  cfg_done <= 1'b1;
               end else if (strap_mode == STRAP_HIGH) begin
                  st <= ST_HOST;
               end else begin
                  st <= ST_ROM;
               end
            end
            ST_ROM, ST_HOST: begin
               if (st == ST_ROM && sck_fall) bit_idx <= bit_idx + 1'b1;
               if (sh_full) begin
                  st       <= ST_DONE;
                  cfg_word <= sh_word;
                  cfg_done <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign cmd_sh     = CMD_BITS << bit_idx;
   assign strap_oe   = (st == ST_ROM);
   assign strap_dout = strap_oe && (bit_idx < CMD_END) && cmd_sh[CMD_W-1];

   p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_ROM) |-> !rom_sck);
   p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rom_sck |-> $stable(strap_dout));
   p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> (cfg_done && $stable(cfg_word)));
   p_word_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> (cfg_word == '0));
endmodule

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
   localparam int W  = 16;
   localparam int HD = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [1:0] strap_mode = 2'b00;
   logic       host_sck = 1'b0, host_q = 1'b0, rom_q = 1'b0, use_rom = 1'b0;
   logic       ser_din;
   logic       rom_sck, strap_dout, strap_oe, cfg_done;
   logic [W-1:0] cfg_word;

   assign ser_din = use_rom ? rom_q : host_q;

   cfg_loader #(.CFG_W(W), .ADDR_W(6), .HALF_DIV(HD), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .rom_sck(rom_sck),
      .strap_dout(strap_dout), .strap_oe(strap_oe), .ser_din(ser_din),
      .host_sck(host_sck), .cfg_word(cfg_word), .cfg_done(cfg_done)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // serial memory model
   logic [W-1:0] rom_mem = '0;
   int           rises = 0, oe_bad = 0;
   logic [8:0]   cmd_seen = '0;
   always begin
      @(posedge rom_sck);
      rises++;
      if (rises <= 9) begin
         cmd_seen = {cmd_seen[7:0], strap_dout};
         if (!strap_oe) oe_bad++;
      end
      if (rises >= 10 && rises <= 25) begin
         #5 rom_q = rom_mem[rises-10];
      end
   end

   // half-period monitor
   logic prev_s = 1'b0;
   int   run_len = 0, seen = 0, len_bad = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_s = 1'b0; seen = 0; run_len = 0;
      end else if (rom_sck != prev_s) begin
         if (seen != 0 && run_len != HD) len_bad++;
         seen = 1; run_len = 1; prev_s = rom_sck;
      end else begin
         run_len++;
      end
   end

   task automatic start(input logic [1:0] m, input bit rom);
      @(negedge clk);
      rst_n = 1'b0; strap_mode = m; use_rom = rom;
      host_sck = 1'b0; host_q = 1'b0; rom_q = 1'b0;
      rises = 0; cmd_seen = '0; oe_bad = 0; len_bad = 0;
      repeat (3) @(negedge clk);
      chk(!cfg_done && cfg_word == '0 && !rom_sck && !strap_oe, "R1 reset state",
          {cfg_done, rom_sck, strap_oe, 13'd0, cfg_word}, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic wait_done();
      for (int n = 0; n < 5000 && !cfg_done; n++) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      host_q = b;
      repeat (3) @(negedge clk);
      host_sck = 1'b1;
      repeat (4) @(negedge clk);
      host_sck = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic after_done(input logic [W-1:0] exp);
      strap_mode = 2'b01;
      for (int i = 0; i < 4; i++) send_bit(~exp[i]);
      strap_mode = 2'b10;
      repeat (10) @(negedge clk);
      chk(cfg_done && cfg_word == exp && !rom_sck, "R9 held after done", cfg_word, exp);
   endtask

   task automatic rom_run(input logic [W-1:0] pat, input logic [1:0] code, input bit flip);
      rom_mem = pat;
      start(code, 1'b1);
      @(negedge clk);
      if (flip) strap_mode = 2'b00;   // R2: late strap change
      repeat (20) @(negedge clk);
      chk(!cfg_done && cfg_word == '0, "R10 zero before done", cfg_word, 32'd0);
      wait_done();
      chk(cfg_done && cfg_word == pat, flip ? "R2 R6 rom word" : "R6 rom word", cfg_word, pat);
      chk(cmd_seen == 9'b110000000 && oe_bad == 0, "R5 command", cmd_seen, 9'b110000000);
      chk(len_bad == 0, "R4 half periods", len_bad, 0);
      repeat (2 * HD) @(negedge clk);
      chk(!rom_sck && !strap_oe && rises == 25, "R7 clock stop", rises, 25);
      after_done(pat);
   endtask

   task automatic host_run(input logic [W-1:0] pat);
      start(2'b01, 1'b0);
      for (int i = 0; i < W - 1; i++) send_bit(pat[i]);
      repeat (8) @(negedge clk);
      chk(!cfg_done && !rom_sck && !strap_oe, "R8 not done after 15 edges",
          {cfg_done, rom_sck, strap_oe}, 0);
      send_bit(pat[W-1]);
      wait_done();
      chk(cfg_done && cfg_word == pat, "R8 host word", cfg_word, pat);
      after_done(pat);
   endtask

   initial begin
      // wired mode
      start(2'b00, 1'b0);
      host_q = 1'b1;
      @(negedge clk);
      chk(cfg_done && cfg_word == '0, "R3 wired done at first edge", {cfg_done, cfg_word}, 32'h10000);
      strap_mode = 2'b01;
      for (int i = 0; i < W; i++) send_bit(1'b1);
      chk(cfg_done && cfg_word == '0 && !rom_sck && !strap_oe, "R3 R2 wired ignores inputs", cfg_word, 0);

      for (int k = 0; k < W; k++)
         rom_run(W'(1) << k, (k % 2 != 0) ? 2'b10 : 2'b11, k == 5);
      rom_run(16'hA5C3, 2'b10, 1'b0);
      rom_run(16'hFFFF, 2'b11, 1'b1);
      rom_run(16'h0000, 2'b10, 1'b0);

      for (int k = 0; k < W; k++) host_run(W'(1) << k);
      host_run(16'h5A3C);
      host_run(16'hFFFF);

      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule